// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a slave is holding by keeping SDA low. A single trigger pulse takes the bus away from the normal transfer engine. The engine is held disabled and told to flush its pending flags. The sequencer then drives the open-drain output enables itself and clocks SCL in bursts of pulses. It samples SDA after every burst. When SDA is seen high, it builds a STOP condition and hands the pins back. If the line never comes free within the programmed number of bursts, it gives up and reports a timeout.

Pin outputs are active-high pull enables: a 1 pulls the wire low and a 0 releases it. While the sequencer is idle, the pin enables come straight from the engine. Pulse timing is set by a half-period parameter counted in system clock cycles. The burst limit is a run-time input.

Top module: `i2c_bus_recover`

## Requirements
- R1: While idle, `sclOe` equals `engSclOe`, `sdaOe` equals `engSdaOe`, and `engHold` is low.
- R2: A trigger accepted in idle gives exactly one cycle of `engFlush`, and `engHold` equals `busy` for the whole recovery.
- R3: A burst is PULSES SCL pulses. Each pulse pulls SCL for HALF_CYCLES cycles and then releases it for HALF_CYCLES cycles. SDA is never pulled while SCL is pulled.
- R4: One cycle follows each burst, with both lines released, in which `sdaIn` is sampled. A further burst starts only if `sdaIn` was low.
- R5: With a limit L = `retryLimit`, where a value of 0 counts as 1, recovery ends in timeout after L bursts that each end with SDA low.
- R6: When SDA is found high, SDA is pulled for 2*HALF_CYCLES cycles with SCL released. Both lines are then released and recovery completes as a success.
- R7: On exit, SCL is released in the last busy cycle. In the first cycle with `busy` low, exactly one of `donePulse` (success) or `timeoutPulse` (timeout) is high, for that single cycle.
- R8: `doneSticky` and `timeoutSticky` record the outcome of the last recovery and are both cleared by the next accepted trigger.
- R9: A trigger while busy is ignored, and the recovery in progress keeps its length.
- R10: A success after B bursts keeps `busy` high for B*(2*PULSES*HALF_CYCLES+1)+2*HALF_CYCLES cycles. A timeout keeps it high for L*(2*PULSES*HALF_CYCLES+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Recovery trigger, sampled in idle |
| retryLimit | input | RETRY_W | Maximum number of bursts, 0 treated as 1 |
| sdaIn | input | 1 | Sampled SDA wire level |
| engSclOe | input | 1 | Transfer engine SCL pull enable |
| engSdaOe | input | 1 | Transfer engine SDA pull enable |
| sclOe | output | 1 | SCL pull enable to the pad |
| sdaOe | output | 1 | SDA pull enable to the pad |
| engHold | output | 1 | Holds the transfer engine disabled with interrupts masked |
| engFlush | output | 1 | One-cycle request to clear the engine's pending flags |
| busy | output | 1 | Recovery in progress |
| donePulse | output | 1 | One-cycle success indication |
| timeoutPulse | output | 1 | One-cycle timeout indication |
| doneSticky | output | 1 | Last recovery succeeded |
| timeoutSticky | output | 1 | Last recovery timed out |

## Verification
The bench models a slave that lets SDA go after a chosen number of bursts. It sweeps that count against several burst limits, including a limit of 0 and a release before the first check. This exposes an off-by-one in the limit compare: the design would give one burst too many or too few and change both the outcome and the busy length. Pulses, STOP hold cycles and clashes between SDA and SCL are counted at the pins. The engine inputs are pulled during recovery, so a broken mux shows up as a clash or a lost STOP. A repeated trigger mid-run catches a design that restarts and stretches the recovery.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_CHECK,
    ST_STOP
  } recovState_t;

  typedef struct packed {
    logic timerClr;
    logic pulseClr;
    logic pulseInc;
    logic burstClr;
    logic burstInc;
  } recovStrobe_t;
endpackage

// File: rtl/i2c_recov_dp.sv
module i2c_recov_dp
  import i2c_recov_pkg::*;
#(
  parameter int HALF_CYCLES = 250,
  parameter int PULSES      = 9,
  parameter int RETRY_W     = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  recovStrobe_t       strobe,
  input  logic [RETRY_W-1:0] retryLimit,
  output logic               halfEnd,
  output logic               stopEnd,
  output logic               lastPulse,
  output logic               lastBurst
);
  localparam int TIMER_W = $clog2(2 * HALF_CYCLES + 1);
  localparam int PULSE_W = $clog2(PULSES + 1);

  logic [TIMER_W-1:0] timer;
  logic [PULSE_W-1:0] pulseCnt;
  logic [RETRY_W-1:0] burstCnt;
  logic [RETRY_W:0]   effLimit;
  logic [RETRY_W:0]   burstsDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer    <= '0;
      pulseCnt <= '0;
      burstCnt <= '0;
    end else begin
      if (strobe.timerClr) timer <= '0;
      else                 timer <= timer + 1'b1;

      if (strobe.pulseClr)      pulseCnt <= '0;
      else if (strobe.pulseInc) pulseCnt <= pulseCnt + 1'b1;

      if (strobe.burstClr)      burstCnt <= '0;
      else if (strobe.burstInc) burstCnt <= burstCnt + 1'b1;
    end
  end

  always_comb begin
    effLimit   = (retryLimit == '0) ? (RETRY_W+1)'(1) : {1'b0, retryLimit};
    burstsDone = {1'b0, burstCnt} + 1'b1;
    halfEnd    = (timer == TIMER_W'(HALF_CYCLES - 1));
    stopEnd    = (timer == TIMER_W'(2 * HALF_CYCLES - 1));
    lastPulse  = (pulseCnt == PULSE_W'(PULSES - 1));
    lastBurst  = (burstsDone >= effLimit);
  end

  p_timer_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TIMER_W'(2 * HALF_CYCLES - 1));
  p_pulse_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < PULSE_W'(PULSES));
endmodule

// File: rtl/i2c_recov_ctrl.sv
module i2c_recov_ctrl
  import i2c_recov_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         sdaIn,
  input  logic         halfEnd,
  input  logic         stopEnd,
  input  logic         lastPulse,
  input  logic         lastBurst,
  output recovStrobe_t strobe,
  output logic         busy,
  output logic         sclPull,
  output logic         sdaPull,
  output logic         engFlush,
  output logic         donePulse,
  output logic         timeoutPulse,
  output logic         doneSticky,
  output logic         timeoutSticky
);
  recovState_t state, nextState;
  logic        trigger;
  logic        finishOk;
  logic        finishTo;

  always_comb begin
    nextState = state;
    strobe    = '0;
    trigger   = 1'b0;
    finishOk  = 1'b0;
    finishTo  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        trigger         = 1'b1;
        nextState       = ST_LOW;
        strobe.pulseClr = 1'b1;
        strobe.burstClr = 1'b1;
      end
      ST_LOW: if (halfEnd) nextState = ST_HIGH;
      ST_HIGH: if (halfEnd) begin
        if (lastPulse) nextState = ST_CHECK;
        else begin
          nextState       = ST_LOW;
          strobe.pulseInc = 1'b1;
        end
      end
      ST_CHECK: begin
        if (sdaIn) nextState = ST_STOP;
        else if (lastBurst) begin
          nextState = ST_IDLE;
          finishTo  = 1'b1;
        end else begin
          nextState       = ST_LOW;
          strobe.pulseClr = 1'b1;
          strobe.burstInc = 1'b1;
        end
      end
      ST_STOP: if (stopEnd) begin
        nextState = ST_IDLE;
        finishOk  = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.timerClr = (nextState != state) || (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      engFlush      <= 1'b0;
      donePulse     <= 1'b0;
      timeoutPulse  <= 1'b0;
      doneSticky    <= 1'b0;
      timeoutSticky <= 1'b0;
    end else begin
      state        <= nextState;
      engFlush     <= trigger;
      donePulse    <= finishOk;
      timeoutPulse <= finishTo;
      if (trigger) begin
        doneSticky    <= 1'b0;
        timeoutSticky <= 1'b0;
      end else begin
        if (finishOk) doneSticky    <= 1'b1;
        if (finishTo) timeoutSticky <= 1'b1;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign sclPull = (state == ST_LOW);
  assign sdaPull = (state == ST_STOP);

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, timeoutPulse}));
  p_pulse_at_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || timeoutPulse) |-> $fell(busy));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && state != ST_CHECK && state != ST_STOP) |=> busy);
  p_check_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) |-> (!sclPull && !sdaPull));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_recov_pkg::*;
#(
  parameter int HALF_CYCLES = 250,
  parameter int PULSES      = 9,
  parameter int RETRY_W     = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic               sdaIn,
  input  logic               engSclOe,
  input  logic               engSdaOe,
  output logic               sclOe,
  output logic               sdaOe,
  output logic               engHold,
  output logic               engFlush,
  output logic               busy,
  output logic               donePulse,
  output logic               timeoutPulse,
  output logic               doneSticky,
  output logic               timeoutSticky
);
  recovStrobe_t strobe;
  logic halfEnd, stopEnd, lastPulse, lastBurst;
  logic sclPull, sdaPull;

  i2c_recov_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .sdaIn        (sdaIn),
    .halfEnd      (halfEnd),
    .stopEnd      (stopEnd),
    .lastPulse    (lastPulse),
    .lastBurst    (lastBurst),
    .strobe       (strobe),
    .busy         (busy),
    .sclPull      (sclPull),
    .sdaPull      (sdaPull),
    .engFlush     (engFlush),
    .donePulse    (donePulse),
    .timeoutPulse (timeoutPulse),
    .doneSticky   (doneSticky),
    .timeoutSticky(timeoutSticky)
  );

  i2c_recov_dp #(
    .HALF_CYCLES(HALF_CYCLES),
    .PULSES     (PULSES),
    .RETRY_W    (RETRY_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .retryLimit(retryLimit),
    .halfEnd   (halfEnd),
    .stopEnd   (stopEnd),
    .lastPulse (lastPulse),
    .lastBurst (lastBurst)
  );

  assign sclOe   = busy ? sclPull : engSclOe;
  assign sdaOe   = busy ? sdaPull : engSdaOe;
  assign engHold = busy;

  p_no_clash_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(sclOe && sdaOe));
  p_exit_scl_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !$past(sclOe));
  p_flush_on_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    engFlush |-> (busy && $rose(busy)));
endmodule

// File: tb/i2c_bus_recover_bench.sv
module i2c_bus_recover_bench;
  localparam int H   = 3;
  localparam int NP  = 9;
  localparam int RW  = 11;
  localparam int BURST = 2 * NP * H + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] retryLimit = '0;
  logic engSclOe = 1'b0, engSdaOe = 1'b0;
  logic slaveHold = 1'b0;
  logic sdaIn;
  logic sclOe, sdaOe, engHold, engFlush, busy;
  logic donePulse, timeoutPulse, doneSticky, timeoutSticky;
  int   tests = 0, fails = 0, cyc = 0;
  bit   hung = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdaIn = ~(sdaOe | slaveHold);

  i2c_bus_recover #(.HALF_CYCLES(H), .PULSES(NP), .RETRY_W(RW)) u_i2c_bus_recover (
    .clk(clk), .rstN(rstN), .start(start), .retryLimit(retryLimit), .sdaIn(sdaIn),
    .engSclOe(engSclOe), .engSdaOe(engSdaOe), .sclOe(sclOe), .sdaOe(sdaOe),
    .engHold(engHold), .engFlush(engFlush), .busy(busy), .donePulse(donePulse),
    .timeoutPulse(timeoutPulse), .doneSticky(doneSticky), .timeoutSticky(timeoutSticky)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCase(input int limit, input int k, input bit reTrig);
    int effL, rel, bursts, expBusy, busyCyc, pulses, stopCyc, clash, holdErr, flushCnt;
    bit ok;
    logic prevScl;
    effL   = (limit == 0) ? 1 : limit;
    rel    = (k == 0) ? 1 : k;
    ok     = (rel <= effL);
    bursts = ok ? rel : effL;
    expBusy = bursts * BURST + (ok ? 2 * H : 0);
    busyCyc = 0; pulses = 0; stopCyc = 0; clash = 0; holdErr = 0; flushCnt = 0;
    prevScl = 1'b0;
    engSclOe = 1'b1; engSdaOe = 1'b1;
    @(negedge clk);
    retryLimit = RW'(limit);
    slaveHold  = (k > 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && !hung) begin
      busyCyc++;
      flushCnt += int'(engFlush);
      if (engHold != busy) holdErr++;
      if (sclOe && !prevScl) pulses++;
      prevScl = sclOe;
      if (sdaOe && !sclOe) stopCyc++;
      if (sdaOe && sclOe) clash++;
      slaveHold = (pulses < NP * k);
      start = reTrig && (busyCyc == 5 || busyCyc == BURST + 2);
      @(negedge clk);
      if (cyc > 150000) hung = 1;
    end
    start = 1'b0;
    check("R10 busy length", busyCyc, expBusy);
    check("R3 SCL pulse count", pulses, bursts * NP);
    check("R3 no SDA pull with SCL pulled", clash, 0);
    check("R6 STOP hold cycles", stopCyc, ok ? 2 * H : 0);
    check("R2 flush count", flushCnt, 1);
    check("R2 hold tracks busy", holdErr, 0);
    check("R7 done pulse", int'(donePulse), int'(ok));
    check("R5 timeout pulse", int'(timeoutPulse), int'(!ok));
    check("R8 done sticky", int'(doneSticky), int'(ok));
    check("R8 timeout sticky", int'(timeoutSticky), int'(!ok));
    @(negedge clk);
    check("R7 pulses single cycle", int'(donePulse) + int'(timeoutPulse), 0);
    check("R1 idle follows engine", int'(sclOe & sdaOe), 1);
    if (reTrig) check("R9 retrigger ignored", busyCyc, expBusy);
  endtask

  initial begin
    int lims[5] = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    check("R8 reset done sticky", int'(doneSticky), 0);
    check("R8 reset timeout sticky", int'(timeoutSticky), 0);
    check("R1 reset busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    engSclOe = 1'b1; engSdaOe = 1'b0;
    #1 check("R1 passthrough scl", int'(sclOe), 1);
    check("R1 passthrough sda", int'(sdaOe), 0);
    check("R1 hold low idle", int'(engHold), 0);
    engSclOe = 1'b0; engSdaOe = 1'b1;
    #1 check("R1 passthrough scl low", int'(sclOe), 0);
    check("R1 passthrough sda high", int'(sdaOe), 1);
    for (int li = 0; li < 5; li++) begin
      for (int k = 0; k <= 6; k++) begin
        if (!hung) runCase(lims[li], k, (k == 2));
      end
    end
    if (!hung) runCase(4, 4, 1'b1);
    if (!hung) runCase(1, 0, 1'b0);
    if (hung) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1600000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails + 1);
    $finish;
  end
endmodule